// File: doc/BRIEF.md
# At-Speed Scan Clock Controller

This controller runs one clock domain through a full scan test sequence during logic test. A single `start` pulse starts a run. The run loads the scan chains with slow shift pulses and then fires a short fast launch/capture burst. It finishes by unloading the responses with slow shift pulses again. Every pulse on `test_clk` is one high phase of the fast on-chip clock. The shift rate is set by a divider ratio from 1 to 16. Only the launch-to-capture interval runs at the full fast rate, and that interval is the only timing that decides at-speed coverage.

Scan enable is allowed to be slow. Around each of its transitions the controller drops fast-clock pulses. This leaves scan enable at least one and a half fast periods to reach every scan cell before the next active edge. Two capture modes are available:

- **Launch-from-capture:** the first fast pulse after the gap moves the circuit into a semi-legal state, and the second pulse captures.
- **Launch-from-shift:** the last shift edge is the launch, and the capture follows one fast period later.

Configuration is sampled when the run starts. A one-cycle `done` pulse marks the end of the final unload.

Top module: `atspeed_clk_ctl`

## Requirements
- R1: While reset is asserted and directly after it, `test_clk`, `scan_en`, `busy` and `done` are all low.
- R2: A `start` seen at a fast rising edge while idle with a nonzero length raises `busy` from that edge. `scan_en` rises half a fast period later, and the first load pulse rises 1.5 fast periods after `scan_en`.
- R3: The load phase and the unload phase each give exactly `cfg_len` pulses. Successive rising edges inside a phase are `cfg_div`+1 fast periods apart, and every `test_clk` pulse is high for exactly half a fast period.
- R4: With `cfg_mode`=0 (launch-from-capture), `scan_en` falls 1.5 fast periods after the last load edge. The launch pulse rises 3 fast periods after that edge and the capture pulse 1 fast period after the launch, for 2·`cfg_len`+2 pulses in total.
- R5: With `cfg_mode`=1 (launch-from-shift), `scan_en` falls half a fast period after the last load edge. The capture pulse rises 1 fast period after that edge, for 2·`cfg_len`+1 pulses in total.
- R6: After the capture edge, `scan_en` rises 1.5 fast periods later and the first unload pulse rises 3 fast periods later.
- R7: Each run has exactly two rising and two falling `scan_en` edges. No `test_clk` pulse occurs in the fast high phase that follows a rising `scan_en` edge, so the next rising edge is at least 1.5 fast periods away.
- R8: While idle, `test_clk` gives no pulses, and `scan_en` is low from the second idle cycle on.
- R9: `done` is high for exactly one fast cycle, starting at the rising edge of the final unload pulse. `scan_en` falls 1.5 fast periods after that edge, and `busy` is low once `done` has dropped.
- R10: `cfg_div`, `cfg_len` and `cfg_mode` are sampled only when a run starts. Changing them during a run alters neither the pulse pattern nor the `scan_en` edges.
- R11: A `start` while `busy` is high is ignored: no second run follows the current one.
- R12: A `start` with `cfg_len`=0 is ignored: `busy` stays low and no pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fastest on-chip clock; source of every test clock pulse |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, sampled on the fast rising edge |
| cfg_div | input | DIV_W | Shift period minus one, in fast periods |
| cfg_len | input | LEN_W | Shift pulses per load and per unload |
| cfg_mode | input | 1 | 0: launch-from-capture, 1: launch-from-shift |
| test_clk | output | 1 | Gated test clock to the domain's scan cells |
| scan_en | output | 1 | Scan enable, changed on falling fast edges |
| busy | output | 1 | High from the start edge until the run ends |
| done | output | 1 | One-cycle pulse at the end of the final unload |

## Verification
The properties assume that `rst_n` is held low from time zero over several fast cycles. They also assume that `start` and the configuration inputs change only on falling fast edges, so that each rising edge sees them settled. The bench drives every input at falling edges to meet both points. It keeps `cfg_div` and `cfg_len` inside their stated ranges. Apart from the zero-length case, it starts runs only with nonzero lengths.

// File: rtl/atspeed_clk_ctl.sv
module atspeed_clk_ctl #(
  parameter int DIV_W = 4,
  parameter int LEN_W = 10
) (
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_mode,
  output logic             test_clk,
  output logic             scan_en,
  output logic             busy,
  output logic             done
);

  localparam logic [2:0]       LAST_LOC = 3'd5;
  localparam logic [2:0]       LAST_LOS = 3'd2;
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
  localparam logic [DIV_W-1:0] DIV_ONE  = DIV_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOAD, S_FAST, S_UNLD, S_FIN} st_t;

  st_t              st_q;
  logic [DIV_W-1:0] div_q, dcnt_q;
  logic [LEN_W-1:0] len_q, left_q;
  logic             mode_q;
  logic [2:0]       step_q;
  logic             fast_en, fast_se, gate_en, se_pre, gate_lat;
  logic             shifting, pulse_slot, last_pulse, last_step;

  assign shifting   = (st_q == S_LOAD) || (st_q == S_UNLD);
  assign pulse_slot = (dcnt_q == '0);
  assign last_pulse = pulse_slot && (left_q == LEN_ONE);
  assign last_step  = (step_q == (mode_q ? LAST_LOS : LAST_LOC));

  // fast window, one step per fast cycle after the last load pulse
  always_comb begin
    fast_en = 1'b0;
    fast_se = 1'b0;
    if (mode_q) begin
      case (step_q)
        3'd0:    fast_en = 1'b1;
        3'd2:    fast_se = 1'b1;
        default: ;
      endcase
    end else begin
      case (step_q)
        3'd0, 3'd5: fast_se = 1'b1;
        3'd2, 3'd3: fast_en = 1'b1;
        default:    ;
      endcase
    end
  end

  assign gate_en = (shifting && pulse_slot) || ((st_q == S_FAST) && fast_en);
  assign se_pre  = (st_q == S_LEAD) || shifting || (st_q == S_FIN) ||
                   ((st_q == S_FAST) && fast_se);
  assign busy    = (st_q != S_IDLE);
  assign done    = (st_q == S_FIN);

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      div_q  <= '0;
      len_q  <= '0;
      mode_q <= 1'b0;
      dcnt_q <= '0;
      left_q <= '0;
      step_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start && (cfg_len != '0)) begin
          div_q  <= cfg_div;
          len_q  <= cfg_len;
          mode_q <= cfg_mode;
          st_q   <= S_LEAD;
        end
        S_LEAD: begin
          dcnt_q <= '0;
          left_q <= len_q;
          st_q   <= S_LOAD;
        end
        S_LOAD, S_UNLD: begin
          if (!pulse_slot) begin
            dcnt_q <= dcnt_q - DIV_ONE;
          end else if (last_pulse) begin
            st_q   <= (st_q == S_LOAD) ? S_FAST : S_FIN;
            step_q <= '0;
          end else begin
            dcnt_q <= div_q;
            left_q <= left_q - LEN_ONE;
          end
        end
        S_FAST: begin
          if (last_step) begin
            st_q   <= S_UNLD;
            dcnt_q <= '0;
            left_q <= len_q;
          end else begin
            step_q <= step_q + 3'd1;
          end
        end
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // scan enable moves on the falling edge, inside a suppressed slot
  always_ff @(negedge clk_fast or negedge rst_n) begin
    if (!rst_n) scan_en <= 1'b0;
    else        scan_en <= se_pre;
  end

  // enable held while the clock is high: whole high phases only
  always_latch begin
    if (!clk_fast) gate_lat = gate_en;
  end

  assign test_clk = clk_fast & gate_lat;

endmodule

// File: rtl/atspeed_clk_ctl_chk.sv
module atspeed_clk_ctl_chk (
  input logic clk_fast,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic scan_en,
  input logic test_clk
);

  AST_BUSY_NEEDS_START: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_IN_RUN: assert property (@(posedge clk_fast) disable iff (!rst_n)
    done |-> busy); // R9

  AST_QUIET_IDLE: assert property (@(negedge clk_fast) disable iff (!rst_n)
    !busy |-> !test_clk); // R8

  AST_SE_LOW_IDLE: assert property (@(negedge clk_fast) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> !scan_en); // R8

  AST_SE_RISE_GAP: assert property (@(negedge clk_fast) disable iff (!rst_n)
    $rose(scan_en) |-> !test_clk); // R7

endmodule

bind atspeed_clk_ctl atspeed_clk_ctl_chk u_chk (
  .clk_fast (clk_fast),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .scan_en  (scan_en),
  .test_clk (test_clk)
);

// File: tb/atspeed_clk_ctl_bench.sv
module atspeed_clk_ctl_bench;
  localparam int CLK_P = 10;
  localparam int HP    = CLK_P / 2;

  logic       clk_fast = 1'b0;
  logic       rst_n    = 1'b0;
  logic       start    = 1'b0;
  logic [3:0] cfg_div  = '0;
  logic [9:0] cfg_len  = '0;
  logic       cfg_mode = 1'b0;
  logic       test_clk, scan_en, busy, done;

  int n_chk = 0;
  int n_bad = 0;

  longint e_t [0:255];
  longint r_t [0:255];
  longint f_t [0:255];
  longint d_t [0:255];
  int     n_edge = 0, n_rise = 0, n_fall = 0, n_done = 0, n_wbad = 0;
  longint last_rise = 0;

  atspeed_clk_ctl u_atspeed_clk_ctl (
    .clk_fast (clk_fast), .rst_n (rst_n), .start (start),
    .cfg_div (cfg_div), .cfg_len (cfg_len), .cfg_mode (cfg_mode),
    .test_clk (test_clk), .scan_en (scan_en), .busy (busy), .done (done)
  );

  always #(HP) clk_fast = ~clk_fast;

  always @(posedge test_clk) begin
    if (n_edge < 256) e_t[n_edge] = $time;
    n_edge++;
    last_rise = $time;
  end
  always @(negedge test_clk) if ($time - last_rise != HP) n_wbad++;
  always @(posedge scan_en) begin
    if (n_rise < 256) r_t[n_rise] = $time;
    n_rise++;
  end
  always @(negedge scan_en) begin
    if (n_fall < 256) f_t[n_fall] = $time;
    n_fall++;
  end
  always @(negedge clk_fast) if (done === 1'b1) begin
    if (n_done < 256) d_t[n_done] = $time;
    n_done++;
  end

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    int b_e;
    repeat (3) @(negedge clk_fast);
    chk_eq("R1 test_clk in reset", test_clk, 0);
    chk_eq("R1 scan_en in reset", scan_en, 0);
    chk_eq("R1 busy/done in reset", {busy, done}, 0);
    rst_n = 1'b1;
    b_e = n_edge;
    repeat (6) @(negedge clk_fast);
    chk_eq("R1 outputs after reset", {test_clk, scan_en, busy, done}, 0);
    chk_eq("R8 no idle pulses", n_edge - b_e, 0);
  endtask

  task automatic t_run(input int dv, input int ln, input bit md, input bit disturb);
    int b_e, b_r, b_f, b_d, b_w, ne, nr, nf, nd, nexp, cap, lst, bad, w;
    longint sp;
    b_e = n_edge; b_r = n_rise; b_f = n_fall; b_d = n_done; b_w = n_wbad;
    sp = longint'(dv + 1) * CLK_P;
    @(negedge clk_fast);
    cfg_div = 4'(dv); cfg_len = 10'(ln); cfg_mode = md;
    chk_eq("R2 idle before start", busy, 0);
    start = 1'b1;
    @(negedge clk_fast);
    chk_eq("R2 busy after start edge", busy, 1);
    start = 1'b0;
    if (disturb) begin
      repeat (4) @(negedge clk_fast);
      cfg_div = ~cfg_div; cfg_len = 10'(ln + 3); cfg_mode = !md;
      start = 1'b1; // R11 start while busy
      @(negedge clk_fast);
      start = 1'b0;
    end
    w = 0;
    while (done !== 1'b1 && w < 4000) begin
      @(negedge clk_fast);
      w++;
    end
    chk_eq("R9 run completes", (w < 4000) ? 1 : 0, 1);
    repeat (12) @(negedge clk_fast);
    chk_eq("R9 busy cleared", busy, 0);
    ne = n_edge - b_e; nr = n_rise - b_r; nf = n_fall - b_f; nd = n_done - b_d;
    nexp = 2 * ln + (md ? 1 : 2);
    chk_eq(disturb ? "R10/R11 pulse count" : (md ? "R5 pulse count" : "R4 pulse count"), ne, nexp);
    chk_eq("R7 se rising edges", nr, 2);
    chk_eq("R7 se falling edges", nf, 2);
    chk_eq("R9 single done cycle", nd, 1);
    chk_eq("R3 pulse width", n_wbad - b_w, 0);
    if (ne == nexp && nr == 2 && nf == 2 && nd == 1) begin
      cap = md ? ln : ln + 1;
      lst = nexp - 1;
      bad = 0;
      for (int i = 1; i < ln; i++) if (e_t[b_e+i] - e_t[b_e+i-1] != sp) bad++;
      chk_eq("R3 load spacing", bad, 0);
      if (md) begin
        chk_eq("R5 capture after last shift", e_t[b_e+ln] - e_t[b_e+ln-1], CLK_P);
        chk_eq("R5 se fall", f_t[b_f] - e_t[b_e+ln-1], HP);
      end else begin
        chk_eq("R4 launch gap", e_t[b_e+ln] - e_t[b_e+ln-1], 3 * CLK_P);
        chk_eq("R4 capture after launch", e_t[b_e+ln+1] - e_t[b_e+ln], CLK_P);
        chk_eq("R4 se fall", f_t[b_f] - e_t[b_e+ln-1], 3 * HP);
      end
      chk_eq("R6 first unload", e_t[b_e+cap+1] - e_t[b_e+cap], 3 * CLK_P);
      chk_eq("R6 se rise after capture", r_t[b_r+1] - e_t[b_e+cap], 3 * HP);
      chk_eq("R7 se settle before unload", e_t[b_e+cap+1] - r_t[b_r+1], 3 * HP);
      bad = 0;
      for (int i = cap + 2; i <= lst; i++) if (e_t[b_e+i] - e_t[b_e+i-1] != sp) bad++;
      chk_eq("R3 unload spacing", bad, 0);
      chk_eq("R2 se lead before first load", e_t[b_e] - r_t[b_r], 3 * HP);
      chk_eq("R9 se final fall", f_t[b_f+1] - e_t[b_e+lst], 3 * HP);
      chk_eq("R9 done timing", d_t[b_d] - e_t[b_e+lst], HP);
    end
  endtask

  task automatic t_zero_len();
    int b_e, b_r, hits;
    b_e = n_edge; b_r = n_rise; hits = 0;
    @(negedge clk_fast);
    cfg_len = '0; cfg_div = 4'd1; cfg_mode = 1'b0;
    start = 1'b1;
    @(negedge clk_fast);
    start = 1'b0;
    repeat (10) begin
      if (busy !== 1'b0) hits++;
      @(negedge clk_fast);
    end
    chk_eq("R12 busy stays low", hits, 0);
    chk_eq("R12 no pulses", n_edge - b_e, 0);
    chk_eq("R12 no scan_en rise", n_rise - b_r, 0);
  endtask

  initial begin
    #(longint'(CLK_P) * 100000);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_run(0, 3, 1'b0, 1'b0);
    t_run(3, 4, 1'b0, 1'b0);
    t_run(15, 2, 1'b1, 1'b0);
    t_run(0, 1, 1'b1, 1'b0);
    t_run(1, 5, 1'b1, 1'b0);
    t_run(0, 1, 1'b0, 1'b0);
    t_run(2, 3, 1'b0, 1'b1);
    t_run(4, 2, 1'b1, 1'b1);
    t_zero_len();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule